// File: doc/BRIEF.md
# Quadratic-Interpolating Sine/Cosine Unit

This block turns a signed fixed-point angle in radians into its sine and cosine, both as signed Q1.15 values. The angle is first multiplied by a constant close to 1/(2π) and the product is truncated toward zero, which gives a 16-bit unsigned fraction of one turn. Whole turns drop off, so any representable angle wraps onto the circle. The six most significant bits of that fraction pick one of 64 equal segments of the circle. The remaining ten bits are an offset d within the segment, and the result is a quadratic in d.

Every segment has its own coefficient triple (c0, c1, c2) for sine and another for cosine. The triples sit in two read-only tables that are computed when the design is elaborated and are wired only into the interpolators. Both datapaths run side by side on the same turn fraction. Each one evaluates (c2·d + c1)·d + c0 in narrow fixed point, then rounds and clips to Q1.15.

The unit is a three-stage pipeline (scale, table read, polynomial) and accepts one angle per cycle with no back-pressure. Because everything is fixed point, results are quantized. For a very small angle the sine output may be zero or a few LSBs away from x, and that is acceptable.

Top module: `turn_sincos_interp`

## Requirements
- R1: While rst_n is low (synchronous, active low), in_ready and out_valid are 0. in_ready is 1 from the first clock edge that samples rst_n high and stays 1 after that.
- R2: An angle accepted (in_valid and in_ready high) at rising edge N produces out_valid high during the cycle after edge N+2. Otherwise out_valid is low.
- R3: For every accepted in_phase (signed, 12 fractional bits, in radians), out_sin/32768 and out_cos/32768 are each within 0.002 of the true sine and cosine of in_phase/4096.
- R4: Angles beyond ±π, up to the full input range of -8 to +8 rad, wrap by whole turns. The angle is scaled to a 16-bit turn fraction by truncating toward zero, and the fraction is taken modulo one turn.
- R5: An angle of exactly 0 gives out_sin = 0 and out_cos = 32767 (+1.0 clipped to the largest Q1.15 code).
- R6: A result whose exact value is +1.0 is clipped to 32767. For example, the angle code 6434 (≈π/2) gives out_sin within tolerance of 32767, and the matching negative angle gives out_sin near −32768.
- R7: Results for tiny angles (|in_phase| ≤ 4 codes) are quantized. The sine may come out as zero or a few LSBs off sin(x) ≈ x, and only the R3 tolerance is required.
- R8: While out_valid is low, out_sin and out_cos keep the values of the last result (0 after reset).
- R9: Back-to-back angles give one result per cycle, in input order, and every accepted angle produces exactly one result.
- R10: Every result satisfies out_sin² + out_cos² within 1% of 32768².

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | in_phase carries an angle |
| in_ready | output | 1 | Unit accepts an angle this cycle |
| in_phase | input | 16 | Signed angle in radians, 12 fractional bits |
| out_valid | output | 1 | out_sin/out_cos carry a new result |
| out_sin | output | 16 | Sine, signed Q1.15 |
| out_cos | output | 16 | Cosine, signed Q1.15 |

## Verification
The main datapath is driven in three ways. First, a long run of uniformly random 16-bit angles with random idle cycles covers all 64 segments and every offset range, so a wrong coefficient, a wrong segment split or a wrong Horner step shows up as a tolerance miss. Second, directed angles at 0, at ±1 and ±4 codes, at ±π/2, ±π, π/4, 2π and the two input extremes separate the clipping, the quantization of tiny angles and the truncating wrap beyond one turn from the ordinary case. Third, a burst of back-to-back angles followed by idle gaps separates correct streaming order and latency from output holding.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Input angle: signed radians with PHASE_FRAC fractional bits
  localparam int PHASE_W    = 16;
  localparam int PHASE_FRAC = 12;
  // Fractional bits of the 1/(2*pi) scaling constant
  localparam int SCALE_FRAC = 20;
  // Turn fraction split into segment index and in-segment offset
  localparam int TURN_W     = 16;
  localparam int SEG_BITS   = 6;
  localparam int OFS_W      = TURN_W - SEG_BITS;
  localparam int N_SEG      = 1 << SEG_BITS;
  // Coefficients: signed, COEF_FRAC fractional bits, room for +1.0
  localparam int COEF_FRAC  = 17;
  localparam int COEF_W     = COEF_FRAC + 2;
  // Output Q1.15
  localparam int OUT_W      = 16;
  localparam int NCH        = 2;   // channel 0 sine, channel 1 cosine

  localparam real TWO_PI     = 6.283185307179586;
  localparam real HALF_TURN  = 3.141592653589793;
  localparam real INV_TWO_PI = 0.159154937;

  localparam int SCALE_K    = int'(INV_TWO_PI * (2.0 ** SCALE_FRAC));
  localparam int K_W        = $clog2(SCALE_K + 1) + 1;
  localparam int PROD_W     = PHASE_W + K_W;
  localparam int TURN_SHIFT = PHASE_FRAC + SCALE_FRAC - TURN_W;

  localparam int ACC_W      = COEF_W + OFS_W + 2;
  localparam int DROP       = COEF_FRAC - (OUT_W - 1);

  localparam logic signed [PROD_W-1:0] P_ONE = PROD_W'(1);
  localparam logic signed [ACC_W-1:0]  A_RND = ACC_W'(1 << (DROP - 1));
  localparam logic signed [ACC_W-1:0]  A_MAX = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0]  A_MIN = ACC_W'(-(1 << (OUT_W - 1)));

  typedef logic signed [COEF_W-1:0] coef_t;

  typedef struct packed {
    coef_t c2;
    coef_t c1;
    coef_t c0;
  } coef_set_t;

  // Angle to turn fraction: multiply by 1/(2*pi), truncate toward zero,
  // keep the low TURN_W bits (modulo one turn).
  function automatic logic [TURN_W-1:0] phase_to_turn(input logic signed [PHASE_W-1:0] ph);
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] quo;
    logic [TURN_SHIFT-1:0]    lost;
    prod = PROD_W'(ph) * PROD_W'(SCALE_K);
    quo  = prod >>> TURN_SHIFT;
    lost = prod[TURN_SHIFT-1:0];
    if (prod[PROD_W-1] && (lost != '0)) quo = quo + P_ONE;
    return quo[TURN_W-1:0];
  endfunction

  // Elaboration-time sine of an argument given in turns (0 .. 1.25)
  function automatic real turn_sine(input real turns);
    real a;
    real term;
    real sum;
    a = turns * TWO_PI;
    if (a > HALF_TURN) a = a - TWO_PI;
    if (a > HALF_TURN) a = a - TWO_PI;
    term = a;
    sum  = a;
    for (int k = 1; k < 14; k++) begin
      term = -term * a * a / real'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  function automatic coef_t to_coef(input real v);
    return coef_t'(int'(v * (2.0 ** COEF_FRAC)));
  endfunction

  // Three-point quadratic through segment start, middle and end
  function automatic coef_set_t seg_coefs(input int seg, input bit cosine);
    real base;
    real f0;
    real fm;
    real f1;
    real q2;
    real q1;
    coef_set_t cs;
    base = cosine ? 0.25 : 0.0;
    f0 = turn_sine(base + real'(seg) / real'(N_SEG));
    fm = turn_sine(base + (real'(seg) + 0.5) / real'(N_SEG));
    f1 = turn_sine(base + (real'(seg) + 1.0) / real'(N_SEG));
    q2 = 2.0 * (f1 - 2.0 * fm + f0);
    q1 = f1 - f0 - q2;
    cs.c0 = to_coef(f0);
    cs.c1 = to_coef(q1);
    cs.c2 = to_coef(q2);
    return cs;
  endfunction

  // Horner form (c2*d + c1)*d + c0 with d = ofs / 2^OFS_W, then round and clip
  function automatic logic signed [OUT_W-1:0] horner_eval(input coef_set_t cs,
                                                          input logic [OFS_W-1:0] ofs);
    logic signed [ACC_W-1:0] dd;
    logic signed [ACC_W-1:0] t;
    logic signed [ACC_W-1:0] r;
    dd = ACC_W'({1'b0, ofs});
    t  = (ACC_W'(cs.c2) * dd) >>> OFS_W;
    t  = t + ACC_W'(cs.c1);
    t  = (t * dd) >>> OFS_W;
    r  = t + ACC_W'(cs.c0) + A_RND;
    r  = r >>> DROP;
    if (r > A_MAX) r = A_MAX;
    if (r < A_MIN) r = A_MIN;
    return r[OUT_W-1:0];
  endfunction

endpackage

// File: rtl/tsc_phase_scale.sv
module tsc_phase_scale
  import tsc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic signed [PHASE_W-1:0] phase,
  output logic                     rdy,
  output logic                     vld,
  output logic [TURN_W-1:0]        turn
);

  logic [TURN_W-1:0] turn_d;

  assign turn_d = phase_to_turn(phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      vld  <= 1'b0;
      turn <= '0;
    end else begin
      rdy <= 1'b1;
      vld <= take;
      if (take) turn <= turn_d;
    end
  end

endmodule

// File: rtl/tsc_coef_rom.sv
module tsc_coef_rom
  import tsc_pkg::*;
#(
  parameter bit COSINE = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SEG_BITS-1:0] seg,
  output coef_set_t           q
);

  coef_set_t tab [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_seg
    localparam coef_set_t ENTRY = seg_coefs(g, COSINE);
    assign tab[g] = ENTRY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (en) q <= tab[seg];
  end

endmodule

// File: rtl/tsc_horner_eval.sv
module tsc_horner_eval
  import tsc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  coef_set_t               cs,
  input  logic [OFS_W-1:0]        ofs,
  output logic signed [OUT_W-1:0] y
);

  logic signed [OUT_W-1:0] y_d;

  assign y_d = horner_eval(cs, ofs);

  always_ff @(posedge clk) begin
    if (!rst_n) y <= '0;
    else if (en) y <= y_d;
  end

endmodule

// File: rtl/turn_sincos_interp.sv
module turn_sincos_interp
  import tsc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic signed [PHASE_W-1:0] in_phase,
  output logic                      out_valid,
  output logic signed [OUT_W-1:0]   out_sin,
  output logic signed [OUT_W-1:0]   out_cos
);

  logic                    take;
  logic                    s1_vld;
  logic                    s2_vld;
  logic [TURN_W-1:0]       s1_turn;
  logic [SEG_BITS-1:0]     s1_seg;
  logic [OFS_W-1:0]        s2_ofs;
  logic signed [OUT_W-1:0] y [NCH];

  assign take   = in_valid && in_ready;
  assign s1_seg = s1_turn[TURN_W-1 -: SEG_BITS];

  // Stage 1: scale to turns
  tsc_phase_scale u_scale (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .phase (in_phase),
    .rdy   (in_ready),
    .vld   (s1_vld),
    .turn  (s1_turn)
  );

  // Stage 2 control: carry offset beside the table read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld <= 1'b0;
      s2_ofs <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) s2_ofs <= s1_turn[OFS_W-1:0];
    end
  end

  // Stages 2 and 3 per channel: table read, then polynomial
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    coef_set_t cs;

    tsc_coef_rom #(.COSINE(ch == 1)) u_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (s1_vld),
      .seg   (s1_seg),
      .q     (cs)
    );

    tsc_horner_eval u_poly (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (s2_vld),
      .cs    (cs),
      .ofs   (s2_ofs),
      .y     (y[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else out_valid <= s2_vld;
  end

  assign out_sin = y[0];
  assign out_cos = y[1];

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      take,
  input logic                      in_ready,
  input logic signed [PHASE_W-1:0] in_phase,
  input logic                      out_valid,
  input logic signed [OUT_W-1:0]   out_sin,
  input logic signed [OUT_W-1:0]   out_cos
);

  localparam int NW = 2 * OUT_W + 2;
  localparam logic signed [NW-1:0] NRM_LO = NW'(1063004406);
  localparam logic signed [NW-1:0] NRM_HI = NW'(1084479242);
  localparam logic signed [OUT_W-1:0] ONE_Q = OUT_W'((1 << (OUT_W - 1)) - 1);

  logic [2:0]              vpipe;
  logic [2:0]              zpipe;
  logic signed [NW-1:0]    nrm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpipe <= '0;
      zpipe <= '0;
    end else begin
      vpipe <= {vpipe[1:0], take};
      zpipe <= {zpipe[1:0], take && (in_phase == '0)};
    end
  end

  assign nrm = NW'(out_sin) * NW'(out_sin) + NW'(out_cos) * NW'(out_cos);

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready); // R1

  AST_NO_READY_IN_RESET: assert property (@(posedge clk)
    !rst_n |=> (!in_ready && !out_valid)); // R1

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vpipe[2]); // R2

  AST_ZERO_ANGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zpipe[2]) |-> (out_sin == '0 && out_cos == ONE_Q)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_sin) && $stable(out_cos))); // R8

  AST_UNIT_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (nrm >= NRM_LO && nrm <= NRM_HI)); // R10

endmodule

bind turn_sincos_interp tsc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .take      (take),
  .in_ready  (in_ready),
  .in_phase  (in_phase),
  .out_valid (out_valid),
  .out_sin   (out_sin),
  .out_cos   (out_cos)
);

// File: tb/turn_sincos_interp_test.sv
`timescale 1ns/1ps
module turn_sincos_interp_test;

  localparam real TOL   = 0.002;
  localparam real QSCL  = 32768.0;
  localparam real PFRAC = 4096.0;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_phase = '0;
  logic               in_ready;
  logic               out_valid;
  logic signed [15:0] out_sin;
  logic signed [15:0] out_cos;

  int n_cmp = 0;
  int n_bad = 0;
  int n_sent = 0;
  int n_got = 0;
  bit live = 1'b0;
  bit done = 1'b0;
  logic [2:0] vexp = '0;
  logic signed [15:0] ph_q [$];
  logic signed [15:0] last_sin = '0;
  logic signed [15:0] last_cos = '0;

  always #2.5 clk = ~clk;

  turn_sincos_interp uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_phase  (in_phase),
    .out_valid (out_valid),
    .out_sin   (out_sin),
    .out_cos   (out_cos)
  );

  task automatic check_int(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_near(input string tag, input string what, input int act, input real exp);
    real diff;
    n_cmp++;
    diff = real'(act) / QSCL - exp;
    if (diff < 0.0) diff = -diff;
    if (diff > TOL) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, int'(exp * QSCL));
    end
  endtask

  function automatic string tag_of(input logic signed [15:0] ph);
    int m;
    m = (ph < 0) ? -int'(ph) : int'(ph);
    if (ph == 0) return "R5";
    if (m <= 4) return "R7";
    if (m == 6434) return "R6";
    if (m > 12868) return "R4";
    return "R3";
  endfunction

  // Bench's own view of accepted angles
  always @(posedge clk) begin
    if (!rst_n) vexp <= '0;
    else vexp <= {vexp[1:0], in_valid && in_ready};
    if (rst_n && in_valid && in_ready) begin
      ph_q.push_back(in_phase);
      n_sent++;
    end
  end

  // Output monitor away from the active edge
  always @(negedge clk) begin
    if (live && rst_n) begin
      check_int("R2", "out_valid timing", int'(out_valid), int'(vexp[2]));
      if (out_valid && ph_q.size() > 0) begin
        logic signed [15:0] ph;
        real ang;
        real es;
        real ec;
        real nr;
        string tg;
        ph  = ph_q.pop_front();
        n_got++;
        ang = real'(ph) / PFRAC;
        es  = $sin(ang);
        ec  = $cos(ang);
        tg  = tag_of(ph);
        check_near(tg, "sine", int'(out_sin), es);
        check_near(tg, "cosine", int'(out_cos), ec);
        if (ph == 0) begin
          check_int("R5", "sine of zero", int'(out_sin), 0);
          check_int("R5", "cosine of zero", int'(out_cos), 32767);
        end
        if (ph == 16'sd6434)
          check_int("R6", "clipped sine at quarter turn", int'(out_sin > 16'sd32700), 1);
        nr = (real'(out_sin) * real'(out_sin) + real'(out_cos) * real'(out_cos)) / (QSCL * QSCL);
        check_int("R10", "norm within 1%", int'(nr > 0.99 && nr < 1.01), 1);
        last_sin = out_sin;
        last_cos = out_cos;
      end else if (!out_valid) begin
        check_int("R8", "sine held", int'(out_sin), int'(last_sin));
        check_int("R8", "cosine held", int'(out_cos), int'(last_cos));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  task automatic send(input logic signed [15:0] ph);
    in_valid = 1'b1;
    in_phase = ph;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic signed [15:0] corner [14];
    corner = '{16'sd0, 16'sd1, -16'sd1, 16'sd4, -16'sd4, 16'sd6434, -16'sd6434,
               16'sd12868, -16'sd12868, 16'sd3217, 16'sd25736, 16'sd32767,
               -16'sd32768, -16'sd20000};
    void'($urandom(32'd24681));

    // R1: reset state
    repeat (4) @(negedge clk);
    check_int("R1", "in_ready in reset", int'(in_ready), 0);
    check_int("R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_int("R1", "in_ready after reset", int'(in_ready), 1);
    live = 1'b1;

    // Directed corners, one at a time with gaps (R4..R8)
    for (int i = 0; i < 14; i++) begin
      send(corner[i]);
      idle(4);
    end

    // R9: back-to-back burst, results in order, one per cycle
    for (int i = 0; i < 12; i++) send(16'(i * 2731 - 15000));
    idle(6);
    check_int("R9", "results equal accepted angles after burst", n_got, n_sent);

    // Random stream with random idle cycles (R3)
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 4) != 0) send(16'($urandom));
      else idle(1);
    end
    idle(8);
    check_int("R9", "results equal accepted angles at end", n_got, n_sent);
    finish_run();
  end

endmodule